// File: doc/BRIEF.md
# SPI NAND Power-Up Identification and Setup Sequencer

This block runs once after power-up, or whenever `start` is pulsed, to find out which serial NAND device hangs on a single-lane SPI bus and to put it into a usable state. It issues a read-ID frame and looks the first two returned bytes up in a parameter table of supported parts. For a known part it clears the block-protection feature register. For parts that can read on four lanes it then sets the quad-enable bit with a read-modify-write.

When the sequence ends the block pulses `done` and holds a result code. It also holds the table index and ID of the matched part, plus the lane count and command byte that later page reads and page programs should use. The SPI bus runs in mode 0 with the serial clock at half the system clock. Only bytes are moved during setup; page transfers belong to other logic.

Top module: `spinand_setup`

## Requirements
- R1: Out of reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0, `status` is 2'b00 (not run), both lane counts are 1, `rd_cmd` is 0x03 and `pg_cmd` is 0x02.
- R2: The first frame sends command 0x9F and one dummy byte 0x00, then clocks in three ID bytes. The lookup key is first ID byte in bits 15:8 and second ID byte in bits 7:0, and `part_id` returns that key on success.
- R3: If the first ID byte is 0xFF or 0x00, `status` becomes 2'b10 (no device), no further frame is sent and both lane counts stay 1.
- R4: If no table entry holds the key, `status` becomes 2'b11 (unsupported part) and no further frame is sent.
- R5: For a known part, a one-byte write-enable frame (0x06) is sent, then a set-feature frame 0x1F, 0xA0, 0x00 that clears block protection.
- R6: For a quad-read part whose enable-bit position is not 0xFF, a get-feature frame (0x0F, address) reads that part's enable register. If the bit is already 1, nothing is written. Otherwise a write-enable frame is sent, then 0x1F, address, and the read value with the bit set.
- R7: An enable-bit position of 0xFF means the enable register is neither read nor written, and quad read is still selected for a quad-read part.
- R8: A part with the quad-read capability (capability bit 0) gets `rd_lanes` = 4 and `rd_cmd` = 0x6B; any other part gets 1 and 0x03.
- R9: `pg_lanes` = 4 and `pg_cmd` = 0x32 only when the part has quad-program capability (capability bit 1) and quad read was selected; otherwise 1 and 0x02.
- R10: `busy` rises the cycle after `start` is seen while idle. `done` is a one-cycle pulse with `busy` low. A `start` while busy is ignored.
- R11: On success `status` is 2'b01 and `part_idx` gives the lowest table index whose ID equals the key.
- R12: `spi_mosi` only changes while `spi_sclk` is low. `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_cs_n` stays high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin identification and setup when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| status | output | 2 | 00 not run, 01 ok, 10 no device, 11 unsupported |
| part_idx | output | IW | Table index of matched part |
| part_id | output | 16 | Matched 16-bit ID key |
| rd_lanes | output | 3 | Data lanes for page reads (1 or 4) |
| pg_lanes | output | 3 | Data lanes for page programs (1 or 4) |
| rd_cmd | output | 8 | Read-from-cache command byte |
| pg_cmd | output | 8 | Program-load command byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench drives a behavioural serial NAND model and tries several ID patterns. The cases are:
- A quad part whose enable bit starts clear, and the same part with the bit already set. These tell the read-modify-write apart from the skip.
- A quad part with no enable bit, which must not touch the register yet still gets four lanes.
- A single-lane part, and a part with program-only quad capability. These separate the read and program lane choices.
- First bytes of 0xFF and 0x00, and two unknown keys, one of which has a matching second byte. These tell rejection for an absent device apart from rejection for an unsupported one.

The model counts set-feature writes made without a prior write-enable. It also records which register was written first and the final register contents, so ordering and side effects are visible at the pins.

// File: rtl/spinand_setup.sv
module spinand_setup #(
  parameter int N_PARTS = 4,
  parameter logic [N_PARTS*16-1:0] PART_IDS     = {16'hC212, 16'h98C2, 16'hEFAA, 16'hC8F1},
  parameter logic [N_PARTS*8-1:0]  PART_QE_ADDR = {8'hB0, 8'hB0, 8'hB0, 8'hB0},
  parameter logic [N_PARTS*8-1:0]  PART_QE_BIT  = {8'h00, 8'hFF, 8'hFF, 8'h00},
  parameter logic [N_PARTS*2-1:0]  PART_CAPS    = {2'b10, 2'b00, 2'b11, 2'b11},
  parameter logic [7:0] CMD_RD_X1 = 8'h03,
  parameter logic [7:0] CMD_RD_X4 = 8'h6B,
  parameter logic [7:0] CMD_PG_X1 = 8'h02,
  parameter logic [7:0] CMD_PG_X4 = 8'h32,
  localparam int IW = (N_PARTS > 1) ? $clog2(N_PARTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic [IW-1:0] part_idx,
  output logic [15:0]   part_id,
  output logic [2:0]    rd_lanes,
  output logic [2:0]    pg_lanes,
  output logic [7:0]    rd_cmd,
  output logic [7:0]    pg_cmd,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso
);

  localparam logic [1:0] RES_NONE  = 2'b00;
  localparam logic [1:0] RES_OK    = 2'b01;
  localparam logic [1:0] RES_ABSENT = 2'b10;
  localparam logic [1:0] RES_UNSUP = 2'b11;

  typedef enum logic [2:0] {
    P_IDLE, P_ID, P_WEN_LOCK, P_LOCK, P_GETQE, P_WEN_QE, P_SETQE
  } phase_t;

  phase_t     phase, nxt_phase;
  logic       launch, go;
  logic       sh_on, cs_q, sclk_q;
  logic [2:0] bitc, bytec, nbytes, byte_idx;
  logic [7:0] tx_sr, rx_sr, nb, feat_q;
  logic [15:0] hist;
  logic       last_byte, frame_end;
  logic       hit;
  logic [IW-1:0] hit_idx;
  logic [1:0] cap;
  logic [7:0] qe_addr, qe_bit, qe_mask;
  logic       fin, fin_quad;
  logic [1:0] fin_res;

  assign spi_cs_n = cs_q;
  assign spi_sclk = sclk_q;
  assign spi_mosi = tx_sr[7];

  assign cap     = PART_CAPS[int'(part_idx)*2 +: 2];
  assign qe_addr = PART_QE_ADDR[int'(part_idx)*8 +: 8];
  assign qe_bit  = PART_QE_BIT[int'(part_idx)*8 +: 8];
  assign qe_mask = 8'd1 << qe_bit[2:0];

  assign nbytes    = (phase == P_ID) ? 3'd5 :
                     (phase == P_WEN_LOCK || phase == P_WEN_QE) ? 3'd1 : 3'd3;
  assign last_byte = (bytec == nbytes - 3'd1);
  assign frame_end = sh_on && sclk_q && (bitc == 3'd7) && last_byte;
  assign byte_idx  = launch ? 3'd0 : bytec + 3'd1;

  always_comb begin
    nb = 8'h00;
    case (phase)
      P_ID:                 nb = (byte_idx == 3'd0) ? 8'h9F : 8'h00;
      P_WEN_LOCK, P_WEN_QE: nb = 8'h06;
      P_LOCK:   nb = (byte_idx == 3'd0) ? 8'h1F : (byte_idx == 3'd1) ? 8'hA0 : 8'h00;
      P_GETQE:  nb = (byte_idx == 3'd0) ? 8'h0F : (byte_idx == 3'd1) ? qe_addr : 8'h00;
      P_SETQE:  nb = (byte_idx == 3'd0) ? 8'h1F : (byte_idx == 3'd1) ? qe_addr
                                                : (feat_q | qe_mask);
      default:  nb = 8'h00;
    endcase
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = N_PARTS - 1; i >= 0; i--) begin
      if (PART_IDS[i*16 +: 16] == hist) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_comb begin
    nxt_phase = phase;
    go        = 1'b0;
    fin       = 1'b0;
    fin_res   = RES_OK;
    fin_quad  = 1'b0;
    if (frame_end) begin
      case (phase)
        P_ID: begin
          if (hist[15:8] == 8'hFF || hist[15:8] == 8'h00) begin
            fin = 1'b1; fin_res = RES_ABSENT; nxt_phase = P_IDLE;
          end else if (!hit) begin
            fin = 1'b1; fin_res = RES_UNSUP; nxt_phase = P_IDLE;
          end else begin
            nxt_phase = P_WEN_LOCK; go = 1'b1;
          end
        end
        P_WEN_LOCK: begin nxt_phase = P_LOCK; go = 1'b1; end
        P_LOCK: begin
          if (cap[0] && qe_bit != 8'hFF) begin
            nxt_phase = P_GETQE; go = 1'b1;
          end else begin
            fin = 1'b1; fin_quad = cap[0]; nxt_phase = P_IDLE;
          end
        end
        P_GETQE: begin
          if ((rx_sr & qe_mask) != 8'h00) begin
            fin = 1'b1; fin_quad = 1'b1; nxt_phase = P_IDLE;
          end else begin
            nxt_phase = P_WEN_QE; go = 1'b1;
          end
        end
        P_WEN_QE: begin nxt_phase = P_SETQE; go = 1'b1; end
        P_SETQE:  begin fin = 1'b1; fin_quad = 1'b1; nxt_phase = P_IDLE; end
        default:  nxt_phase = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_on  <= 1'b0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      bitc   <= '0;
      bytec  <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      hist   <= '0;
    end else if (launch) begin
      sh_on  <= 1'b1;
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
      bitc   <= '0;
      bytec  <= '0;
      tx_sr  <= nb;
    end else if (sh_on) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sr  <= {rx_sr[6:0], spi_miso};
      end else begin
        sclk_q <= 1'b0;
        if (bitc == 3'd7) begin
          hist <= {hist[7:0], rx_sr};
          bitc <= '0;
          if (last_byte) begin
            sh_on <= 1'b0;
            cs_q  <= 1'b1;
          end else begin
            bytec <= bytec + 3'd1;
            tx_sr <= nb;
          end
        end else begin
          bitc  <= bitc + 3'd1;
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      launch   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      status   <= RES_NONE;
      part_idx <= '0;
      part_id  <= '0;
      feat_q   <= '0;
      rd_lanes <= 3'd1;
      pg_lanes <= 3'd1;
      rd_cmd   <= CMD_RD_X1;
      pg_cmd   <= CMD_PG_X1;
    end else begin
      launch <= 1'b0;
      done   <= 1'b0;
      if (phase == P_IDLE) begin
        if (start) begin
          phase    <= P_ID;
          launch   <= 1'b1;
          busy     <= 1'b1;
          status   <= RES_NONE;
          part_idx <= '0;
          part_id  <= '0;
          rd_lanes <= 3'd1;
          pg_lanes <= 3'd1;
          rd_cmd   <= CMD_RD_X1;
          pg_cmd   <= CMD_PG_X1;
        end
      end else if (frame_end) begin
        phase  <= nxt_phase;
        launch <= go;
        if (phase == P_ID && go) begin
          part_idx <= hit_idx;
          part_id  <= hist;
        end
        if (phase == P_GETQE) feat_q <= rx_sr;
        if (fin) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          status <= fin_res;
          if (fin_quad) begin
            rd_lanes <= 3'd4;
            rd_cmd   <= CMD_RD_X4;
            if (cap[1]) begin
              pg_lanes <= 3'd4;
              pg_cmd   <= CMD_PG_X4;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/spinand_setup_chk.sv
module spinand_setup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic [2:0] rd_lanes,
  input logic [2:0] pg_lanes,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);

  // R12
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sclk);

  // R12
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  pg_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_lanes == 3'd4) |-> (rd_lanes == 3'd4));

  // R3
  reject_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[1]) |-> (rd_lanes == 3'd1 && pg_lanes == 3'd1));

endmodule

bind spinand_setup spinand_setup_chk u_chk (.*);

// File: tb/test_spinand_setup.sv
module test_spinand_setup;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] id0, id1, b0;
    logic [1:0] st;
    logic [2:0] rl, pl;
    logic [7:0] rc, pc;
    logic [3:0] nset, nget;
    logic [1:0] idx;
    logic [7:0] b0f;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hC8, 8'hF1, 8'h10, 2'b01, 3'd4, 3'd4, 8'h6B, 8'h32, 4'd2, 4'd1, 2'd0, 8'h11},
    '{8'hC8, 8'hF1, 8'h11, 2'b01, 3'd4, 3'd4, 8'h6B, 8'h32, 4'd1, 4'd1, 2'd0, 8'h11},
    '{8'hEF, 8'hAA, 8'h10, 2'b01, 3'd4, 3'd4, 8'h6B, 8'h32, 4'd1, 4'd0, 2'd1, 8'h10},
    '{8'h98, 8'hC2, 8'h10, 2'b01, 3'd1, 3'd1, 8'h03, 8'h02, 4'd1, 4'd0, 2'd2, 8'h10},
    '{8'hC2, 8'h12, 8'h10, 2'b01, 3'd1, 3'd1, 8'h03, 8'h02, 4'd1, 4'd0, 2'd3, 8'h10},
    '{8'hFF, 8'h12, 8'h10, 2'b10, 3'd1, 3'd1, 8'h03, 8'h02, 4'd0, 4'd0, 2'd0, 8'h10},
    '{8'h00, 8'hC8, 8'h10, 2'b10, 3'd1, 3'd1, 8'h03, 8'h02, 4'd0, 4'd0, 2'd0, 8'h10},
    '{8'hC8, 8'h00, 8'h10, 2'b11, 3'd1, 3'd1, 8'h03, 8'h02, 4'd0, 4'd0, 2'd0, 8'h10},
    '{8'h2C, 8'hF1, 8'h10, 2'b11, 3'd1, 3'd1, 8'h03, 8'h02, 4'd0, 4'd0, 2'd0, 8'h10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;
  logic [1:0] status, part_idx;
  logic [15:0] part_id;
  logic [2:0] rd_lanes, pg_lanes;
  logic [7:0] rd_cmd, pg_cmd;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] dev_id [3];
  logic [7:0] feat [256];
  logic [7:0] dev_cmd, dev_addr, dev_sr, dev_sh, dummy_or, first_set;
  logic dev_wel;
  int dev_bit, dev_byte;
  int n_id, n_set, n_get, n_bad, n_done, n_viol;
  logic prev_mosi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spinand_setup i_spinand_setup (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .part_idx(part_idx), .part_id(part_id),
    .rd_lanes(rd_lanes), .pg_lanes(pg_lanes), .rd_cmd(rd_cmd), .pg_cmd(pg_cmd),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic dev_take(input int idx, input logic [7:0] b);
    logic [7:0] o;
    o = 8'h00;
    if (idx == 0) begin
      dev_cmd = b;
      if (b == 8'h9F) n_id++;
      if (b == 8'h06) dev_wel = 1'b1;
      if (b == 8'h0F) n_get++;
    end else if (dev_cmd == 8'h9F) begin
      if (idx == 1) dummy_or = dummy_or | b;
      if (idx >= 1 && idx <= 3) o = dev_id[idx-1];
    end else if (dev_cmd == 8'h0F && idx == 1) begin
      o = feat[b];
    end else if (dev_cmd == 8'h1F) begin
      if (idx == 1) dev_addr = b;
      if (idx == 2) begin
        if (dev_wel) begin
          feat[dev_addr] = b;
          n_set++;
          if (n_set == 1) first_set = dev_addr;
        end else n_bad++;
        dev_wel = 1'b0;
      end
    end
    dev_sr = o;
  endtask

  always @(negedge spi_cs_n) begin
    dev_bit = 0; dev_byte = 0; dev_sr = 8'h00; spi_miso = 1'b0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    dev_sh = {dev_sh[6:0], spi_mosi};
    dev_bit++;
    if (dev_bit == 8) begin
      dev_bit = 0;
      dev_take(dev_byte, dev_sh);
      dev_byte++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    spi_miso = dev_sr[7];
    dev_sr = {dev_sr[6:0], 1'b0};
  end

  always @(negedge clk) begin
    if (!spi_cs_n && spi_sclk && spi_mosi !== prev_mosi) n_viol++;
    prev_mosi = spi_mosi;
    if (done) n_done++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dev_setup(input logic [7:0] a, input logic [7:0] b, input logic [7:0] b0);
    dev_id[0] = a; dev_id[1] = b; dev_id[2] = 8'h5A;
    for (int i = 0; i < 256; i++) feat[i] = 8'h00;
    feat[8'hA0] = 8'h7C;
    feat[8'hB0] = b0;
    dev_wel = 1'b0; dummy_or = 8'h00; first_set = 8'h00;
    n_id = 0; n_set = 0; n_get = 0; n_bad = 0; n_done = 0; n_viol = 0;
  endtask

  task automatic wait_done(output bit ok);
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    ok = done;
  endtask

  task automatic run_vec(input vec_t v);
    bit ok;
    dev_setup(v.id0, v.id1, v.b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    wait_done(ok);
    chk(ok, "R10 done reached", ok, 1);
    chk(busy == 1'b0, "R10 busy low at done", busy, 0);
    chk(status == v.st, "R3 R4 R11 status", status, v.st);
    chk(rd_lanes == v.rl, "R8 rd_lanes", rd_lanes, v.rl);
    chk(rd_cmd == v.rc, "R8 rd_cmd", rd_cmd, v.rc);
    chk(pg_lanes == v.pl, "R9 pg_lanes", pg_lanes, v.pl);
    chk(pg_cmd == v.pc, "R9 pg_cmd", pg_cmd, v.pc);
    chk(n_id == 1, "R2 one ID frame", n_id, 1);
    chk(dummy_or == 8'h00, "R2 dummy byte", dummy_or, 0);
    chk(n_set == int'(v.nset), "R5 R6 set-feature count", n_set, v.nset);
    chk(n_get == int'(v.nget), "R6 R7 get-feature count", n_get, v.nget);
    chk(n_bad == 0, "R5 R6 write-enable before set", n_bad, 0);
    chk(feat[8'hB0] == v.b0f, "R6 enable register", feat[8'hB0], v.b0f);
    chk(n_viol == 0, "R12 mosi stable while sclk high", n_viol, 0);
    if (v.st == 2'b01) begin
      chk(feat[8'hA0] == 8'h00, "R5 block lock cleared", feat[8'hA0], 0);
      chk(first_set == 8'hA0, "R5 lock written first", first_set, 8'hA0);
      chk(part_idx == v.idx, "R11 part_idx", part_idx, v.idx);
      chk(part_id == {v.id0, v.id1}, "R2 part_id key", part_id, {v.id0, v.id1});
    end else begin
      chk(feat[8'hA0] == 8'h7C, "R3 R4 no lock write", feat[8'hA0], 8'h7C);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (40) @(negedge clk);
    chk(n_id == 1 && spi_cs_n == 1'b1, "R3 R4 R12 no further frames", n_id, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 bus idle", {spi_cs_n, spi_sclk}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy done", {busy, done}, 0);
    chk(status == 2'b00, "R1 status", status, 0);
    chk(rd_lanes == 3'd1 && pg_lanes == 3'd1, "R1 lanes", {rd_lanes, pg_lanes}, 6'o11);
    chk(rd_cmd == 8'h03 && pg_cmd == 8'h02, "R1 cmds", {rd_cmd, pg_cmd}, 16'h0302);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {spi_cs_n, busy}, 2'b10);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R10 start pulses while busy are ignored
    dev_setup(8'hC8, 8'hF1, 8'h10);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(ok);
    chk(ok, "R10 run completes", ok, 1);
    @(negedge clk);
    repeat (100) @(negedge clk);
    chk(n_id == 1, "R10 start ignored while busy", n_id, 1);
    chk(n_done == 1, "R10 single done pulse", n_done, 1);
    chk(feat[8'hB0] == 8'h11 && n_set == 2, "R6 rerun sets enable bit", feat[8'hB0], 8'h11);

    // R6 enable already set by a prior run: second run reads and skips the write
    n_set = 0; n_get = 0; n_id = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(ok);
    chk(n_get == 1 && n_set == 1, "R6 skip write when set", n_set, 1);
    chk(rd_lanes == 3'd4 && pg_lanes == 3'd4, "R8 R9 quad kept", {rd_lanes, pg_lanes}, 6'o44);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule